// File: doc/BRIEF.md
# Capability Chain Walker with MSI Programming

This block is a configuration sequencer for a root port or host controller. Given a capability ID, it searches the capability list of a remote function. That list lives in the 256-byte PCI-compatible configuration space. The block never assumes where a record sits. It reads the list head from the header, then follows the next pointers one record at a time until one of three things happens: the ID matches, the chain ends, or a hop budget runs out.

When the matching record is the MSI capability, the block goes on to set it up:
- It writes the message address into the record, including the upper half when the function reports 64-bit addressing.
- It writes the message control word with the vector-count field and the enable bit set.
- It does a read-modify-write of the Command register that turns on bus mastering and turns off legacy line-interrupt emulation.

All accesses are whole-dword configuration requests on a simple request/acknowledge port. The host pulses `start` with the target ID. It then waits for `done`, which comes with exactly one of `found` or `not_found`.

Top module: `capw_msi_seq`

## Requirements
- R1: After `start` in idle, the first configuration access is a read of dword address 0x34, and byte 0 of that dword is taken as the list head pointer.
- R2: Each record is read as one dword at the record pointer: byte 0 is the capability ID and byte 1 is the next pointer. The low two bits of every pointer are cleared before use, and every request address is dword aligned.
- R3: A head or next pointer of 0x00 ends the search with `not_found`.
- R4: No more than MAX_HOPS (default 48) records are read per search. If none matches within that budget, the search ends with `not_found` after exactly MAX_HOPS record reads.
- R5: On a match with an ID other than MSI_ID (default 0x05), the search ends with `found`. `cap_loc` then gives the record's dword-aligned address, and no write is issued.
- R6: On an MSI match, bits 31:2 of `msi_addr`, with the low two bits forced to zero, are written to record+4. Bits 63:32 are written to record+8 only when bit 7 of the message control (bit 23 of the record dword) is set.
- R7: The message control is then written with byte enables 4'b1100, in which bits 6:4 are ceil(log2(`msi_vectors`)). A count of 0 or 1 gives 0, and any result is capped at 5. Bit 0 (enable) is 1, and all other control bits keep their read values.
- R8: Last, dword 0x04 is read and written back with byte enables 4'b0011. Bit 10 (legacy interrupt disable) and bit 2 (bus master) are set, and the other bits are unchanged. After that write is acknowledged, the search ends with `found`.
- R9: A request holds `cfg_req`, address, direction and data stable until `cfg_ack`. Each acknowledge completes exactly one access.
- R10: `done` is a one-cycle pulse with exactly one of `found`/`not_found`. The results hold until the next accepted `start`, which clears them. A `start` while busy is ignored.
- R11: After reset, `busy`, `done`, `found`, `not_found` and `cfg_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (accepted only when idle) |
| target_id | input | 8 | Capability ID to search for |
| msi_addr | input | 64 | Message address to program on an MSI match |
| msi_vectors | input | 6 | Requested number of message vectors |
| cfg_req | output | 1 | Configuration request valid |
| cfg_we | output | 1 | 1 = write, 0 = read |
| cfg_addr | output | 8 | Dword-aligned byte address in configuration space |
| cfg_be | output | 4 | Byte enables for writes |
| cfg_wdata | output | 32 | Write data |
| cfg_ack | input | 1 | Access complete; read data valid in the same cycle |
| cfg_rdata | input | 32 | Read data |
| busy | output | 1 | Search or programming in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| found | output | 1 | Last search matched the target |
| not_found | output | 1 | Last search ended without a match |
| cap_loc | output | 8 | Address of the matched record |

## Verification
The bench builds several capability layouts in a configuration-space model:
- a match at the first record and a match deep in the chain;
- a chain that ends with no match, and an empty list;
- pointers whose low bits are set, which a design that fails to mask them would follow to the wrong dword.

A self-referencing record checks the hop budget. A design without the budget hangs on it, and one with an off-by-one stops one read early or late.

MSI setup is tried with both 32-bit and 64-bit control words. Stale vector-count bits are planted in the control word, and a status word in the upper half of 0x04 would be overwritten by a full-width write. Both must survive untouched. A stray write to the upper address dword, or a clobbered control bit, shows up in the final memory contents.

A restart pulse during a long walk must not restart the search. Results must also persist between runs.

// File: rtl/capw_pkg.sv
package capw_pkg;
  localparam int CFG_AW = 8;
  localparam int CFG_DW = 32;
  localparam int CFG_BW = CFG_DW / 8;

  localparam logic [CFG_AW-1:0] HEAD_PTR_OFS = 8'h34;
  localparam logic [CFG_AW-1:0] CMD_OFS      = 8'h04;
  localparam int CMD_LEGACY_OFF_BIT = 10;
  localparam int CMD_MASTER_BIT     = 2;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HEAD,
    ST_REC,
    ST_ADDR_LO,
    ST_ADDR_HI,
    ST_CTRL,
    ST_CMD_RD,
    ST_CMD_WR
  } capw_state_t;

  typedef struct packed {
    logic              we;
    logic [CFG_AW-1:0] addr;
    logic [CFG_BW-1:0] be;
    logic [CFG_DW-1:0] data;
  } cfg_op_t;
endpackage

// File: rtl/capw_req_port.sv
module capw_req_port
  import capw_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    load,
  input  cfg_op_t op_in,
  input  logic    ack,
  output logic    req,
  output cfg_op_t op_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req    <= 1'b0;
      op_out <= '0;
    end else if (load) begin
      req    <= 1'b1;
      op_out <= op_in;
    end else if (ack) begin
      req    <= 1'b0;
    end
  end
endmodule

// File: rtl/capw_hop_guard.sv
module capw_hop_guard #(
  parameter int MAX_HOPS = 48
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic last
);
  localparam int CW = $clog2(MAX_HOPS + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (step)    cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CW'(MAX_HOPS - 1));
endmodule

// File: rtl/capw_mme_enc.sv
module capw_mme_enc #(
  parameter int VEC_W   = 6,
  parameter int MAX_LOG = 5,
  parameter int MME_W   = 3
) (
  input  logic [VEC_W-1:0] count,
  output logic [MME_W-1:0] mme
);
  always_comb begin
    mme = '0;
    for (int i = 0; i < MAX_LOG; i++) begin
      if ((32'd1 << i) < 32'(count)) mme = MME_W'(i + 1);
    end
  end
endmodule

// File: rtl/capw_msi_seq.sv
module capw_msi_seq
  import capw_pkg::*;
#(
  parameter int          MAX_HOPS = 48,
  parameter int          VEC_W    = 6,
  parameter int          MSI_AW   = 64,
  parameter logic [7:0]  MSI_ID   = 8'h05
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        target_id,
  input  logic [MSI_AW-1:0] msi_addr,
  input  logic [VEC_W-1:0]  msi_vectors,
  output logic              cfg_req,
  output logic              cfg_we,
  output logic [CFG_AW-1:0] cfg_addr,
  output logic [CFG_BW-1:0] cfg_be,
  output logic [CFG_DW-1:0] cfg_wdata,
  input  logic              cfg_ack,
  input  logic [CFG_DW-1:0] cfg_rdata,
  output logic              busy,
  output logic              done,
  output logic              found,
  output logic              not_found,
  output logic [CFG_AW-1:0] cap_loc
);
  localparam logic [CFG_AW-1:0] PTR_MASK = ~CFG_AW'(3);
  localparam int                MME_W    = 3;

  capw_state_t       state, nxt;
  logic [7:0]        tgt_q;
  logic [MSI_AW-1:2] addr_q;
  logic [VEC_W-1:0]  vec_q;
  logic [CFG_AW-1:0] cur_ptr;
  logic [15:0]       ctrl_q;
  logic              wide_q;

  logic              load;
  cfg_op_t           op_nxt, op_cur;
  logic              fin_found, fin_nf;
  logic              hop_last, hop_step, hop_clear;
  logic [MME_W-1:0]  mme;

  logic [CFG_AW-1:0] head_ptr, next_ptr;
  logic [7:0]        rec_id;

  assign head_ptr = cfg_rdata[7:0]  & PTR_MASK;
  assign next_ptr = cfg_rdata[15:8] & PTR_MASK;
  assign rec_id   = cfg_rdata[7:0];

  capw_mme_enc #(.VEC_W(VEC_W), .MAX_LOG(5), .MME_W(MME_W)) u_mme (
    .count (vec_q),
    .mme   (mme)
  );

  assign hop_clear = (state == ST_IDLE) && start;
  assign hop_step  = (state == ST_REC) && cfg_ack;

  capw_hop_guard #(.MAX_HOPS(MAX_HOPS)) u_hops (
    .clk   (clk),
    .rst   (rst),
    .clear (hop_clear),
    .step  (hop_step),
    .last  (hop_last)
  );

  capw_req_port u_port (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .op_in  (op_nxt),
    .ack    (cfg_ack),
    .req    (cfg_req),
    .op_out (op_cur)
  );

  assign cfg_we    = op_cur.we;
  assign cfg_addr  = op_cur.addr;
  assign cfg_be    = op_cur.be;
  assign cfg_wdata = op_cur.data;

  // next-state and next-request selection
  always_comb begin
    nxt       = state;
    load      = 1'b0;
    op_nxt    = '0;
    fin_found = 1'b0;
    fin_nf    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          load        = 1'b1;
          op_nxt.addr = HEAD_PTR_OFS;
          nxt         = ST_HEAD;
        end
      end
      ST_HEAD: begin
        if (cfg_ack) begin
          if (head_ptr == '0) begin
            fin_nf = 1'b1;
            nxt    = ST_IDLE;
          end else begin
            load        = 1'b1;
            op_nxt.addr = head_ptr;
            nxt         = ST_REC;
          end
        end
      end
      ST_REC: begin
        if (cfg_ack) begin
          if (rec_id == tgt_q) begin
            if (tgt_q == MSI_ID) begin
              load        = 1'b1;
              op_nxt.we   = 1'b1;
              op_nxt.addr = cur_ptr + CFG_AW'(4);
              op_nxt.be   = '1;
              op_nxt.data = {addr_q[31:2], 2'b00};
              nxt         = ST_ADDR_LO;
            end else begin
              fin_found = 1'b1;
              nxt       = ST_IDLE;
            end
          end else if (next_ptr == '0 || hop_last) begin
            fin_nf = 1'b1;
            nxt    = ST_IDLE;
          end else begin
            load        = 1'b1;
            op_nxt.addr = next_ptr;
            nxt         = ST_REC;
          end
        end
      end
      ST_ADDR_LO: begin
        if (cfg_ack) begin
          load      = 1'b1;
          op_nxt.we = 1'b1;
          if (wide_q) begin
            op_nxt.addr = cur_ptr + CFG_AW'(8);
            op_nxt.be   = '1;
            op_nxt.data = addr_q[63:32];
            nxt         = ST_ADDR_HI;
          end else begin
            op_nxt.addr = cur_ptr;
            op_nxt.be   = 4'b1100;
            op_nxt.data = {ctrl_q, 16'h0000};
            nxt         = ST_CTRL;
          end
        end
      end
      ST_ADDR_HI: begin
        if (cfg_ack) begin
          load        = 1'b1;
          op_nxt.we   = 1'b1;
          op_nxt.addr = cur_ptr;
          op_nxt.be   = 4'b1100;
          op_nxt.data = {ctrl_q, 16'h0000};
          nxt         = ST_CTRL;
        end
      end
      ST_CTRL: begin
        if (cfg_ack) begin
          load        = 1'b1;
          op_nxt.addr = CMD_OFS;
          nxt         = ST_CMD_RD;
        end
      end
      ST_CMD_RD: begin
        if (cfg_ack) begin
          load        = 1'b1;
          op_nxt.we   = 1'b1;
          op_nxt.addr = CMD_OFS;
          op_nxt.be   = 4'b0011;
          op_nxt.data = cfg_rdata;
          op_nxt.data[CMD_LEGACY_OFF_BIT] = 1'b1;
          op_nxt.data[CMD_MASTER_BIT]     = 1'b1;
          nxt         = ST_CMD_WR;
        end
      end
      ST_CMD_WR: begin
        if (cfg_ack) begin
          fin_found = 1'b1;
          nxt       = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tgt_q     <= '0;
      addr_q    <= '0;
      vec_q     <= '0;
      cur_ptr   <= '0;
      ctrl_q    <= '0;
      wide_q    <= 1'b0;
      done      <= 1'b0;
      found     <= 1'b0;
      not_found <= 1'b0;
      cap_loc   <= '0;
    end else begin
      state <= nxt;
      done  <= fin_found | fin_nf;
      if (hop_clear) begin
        tgt_q     <= target_id;
        addr_q    <= msi_addr[MSI_AW-1:2];
        vec_q     <= msi_vectors;
        found     <= 1'b0;
        not_found <= 1'b0;
        cap_loc   <= '0;
      end
      if (load && (nxt == ST_REC)) cur_ptr <= op_nxt.addr;
      if (state == ST_REC && cfg_ack && rec_id == tgt_q) begin
        ctrl_q <= {cfg_rdata[31:23], mme, cfg_rdata[19:17], 1'b1};
        wide_q <= cfg_rdata[23];
      end
      if (fin_found) begin
        found   <= 1'b1;
        cap_loc <= cur_ptr;
      end
      if (fin_nf) not_found <= 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/capw_msi_seq_chk.sv
module capw_msi_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        cfg_req,
  input logic        cfg_ack,
  input logic        cfg_we,
  input logic [7:0]  cfg_addr,
  input logic [3:0]  cfg_be,
  input logic [31:0] cfg_wdata,
  input logic        busy,
  input logic        done,
  input logic        found,
  input logic        not_found
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && !cfg_ack) |=> (cfg_req && $stable(cfg_addr) && $stable(cfg_we) && $stable(cfg_wdata))); // R9
  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (rst)
    cfg_req |-> (cfg_addr[1:0] == 2'b00)); // R2
  AST_CMD_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && cfg_we && cfg_addr == 8'h04) |-> (cfg_be == 4'b0011 && cfg_wdata[10] && cfg_wdata[2])); // R8
  AST_DONE_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    done |-> (found ^ not_found)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(found) && $stable(not_found))); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !cfg_req); // R11
endmodule

bind capw_msi_seq capw_msi_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .cfg_req   (cfg_req),
  .cfg_ack   (cfg_ack),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_be    (cfg_be),
  .cfg_wdata (cfg_wdata),
  .busy      (busy),
  .done      (done),
  .found     (found),
  .not_found (not_found)
);

// File: tb/capw_msi_seq_test.sv
module capw_msi_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  target_id = '0;
  logic [63:0] msi_addr = '0;
  logic [5:0]  msi_vectors = '0;
  logic        cfg_req, cfg_we, cfg_ack;
  logic [7:0]  cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        busy, done, found, not_found;
  logic [7:0]  cap_loc;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0] cs [0:63];
  int rec_reads, head_reads, writes, accesses;
  logic [7:0] first_addr;

  capw_msi_seq uut (
    .clk(clk), .rst(rst), .start(start), .target_id(target_id),
    .msi_addr(msi_addr), .msi_vectors(msi_vectors),
    .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata),
    .busy(busy), .done(done), .found(found), .not_found(not_found), .cap_loc(cap_loc)
  );

  always #10 clk = ~clk;

  // configuration space model: one access per acknowledge
  always @(posedge clk) begin
    if (rst) begin
      cfg_ack   <= 1'b0;
      cfg_rdata <= '0;
    end else begin
      cfg_ack <= cfg_req & ~cfg_ack;
      if (cfg_req && !cfg_ack) begin
        if (accesses == 0) first_addr <= cfg_addr;
        accesses <= accesses + 1;
        if (cfg_we) begin
          writes <= writes + 1;
          for (int b = 0; b < 4; b++)
            if (cfg_be[b]) cs[cfg_addr[7:2]][8*b +: 8] <= cfg_wdata[8*b +: 8];
        end else begin
          cfg_rdata <= cs[cfg_addr[7:2]];
          if (cfg_addr == 8'h34) head_reads <= head_reads + 1;
          else if (cfg_addr != 8'h04) rec_reads <= rec_reads + 1;
        end
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_space();
    for (int i = 0; i < 64; i++) cs[i] = '0;
    rec_reads = 0; head_reads = 0; writes = 0; accesses = 0; first_addr = '0;
  endtask

  task automatic run(input logic [7:0] tgt, input logic [5:0] vec, input logic [63:0] addr);
    int waited;
    @(negedge clk);
    target_id = tgt; msi_vectors = vec; msi_addr = addr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!done && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL R10 no done pulse actual=0 expected=1");
    end
  endtask

  typedef struct packed {
    logic [7:0] p0, i0, p1, i1, p2, i2, tgt;
    logic       ef;
    logic [7:0] eloc, erd;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'h40, 8'h01, 8'h50, 8'h10, 8'h60, 8'h11, 8'h11, 1'b1, 8'h60, 8'd3},
    '{8'h40, 8'h01, 8'h50, 8'h10, 8'h60, 8'h11, 8'h10, 1'b1, 8'h50, 8'd2},
    '{8'h40, 8'h01, 8'h50, 8'h10, 8'h60, 8'h11, 8'h09, 1'b0, 8'h00, 8'd3},
    '{8'h43, 8'h09, 8'h00, 8'h00, 8'h00, 8'h00, 8'h09, 1'b1, 8'h40, 8'd1},
    '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 1'b0, 8'h00, 8'd0},
    '{8'hFC, 8'h01, 8'h81, 8'h03, 8'hC0, 8'h12, 8'h12, 1'b1, 8'hC0, 8'd3}
  };

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_space();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check("R11 busy",      busy,      1'b0);
    check("R11 done",      done,      1'b0);
    check("R11 found",     found,     1'b0);
    check("R11 not_found", not_found, 1'b0);
    check("R11 cfg_req",   cfg_req,   1'b0);

    // table of layouts, non-MSI targets
    for (int k = 0; k < 6; k++) begin
      vec_t v;
      v = VECS[k];
      clear_space();
      cs[8'h34 >> 2] = {24'h0, v.p0};
      if (v.p0 != 0) cs[v.p0[7:2]] = {16'h0, v.p1, v.i0};
      if (v.p1 != 0) cs[v.p1[7:2]] = {16'h0, v.p2, v.i1};
      if (v.p2 != 0) cs[v.p2[7:2]] = {16'h0, 8'h00, v.i2};
      run(v.tgt, 6'd1, 64'h0);
      check(v.ef ? "R5 found" : "R3 found", found, v.ef);
      check(v.ef ? "R5 not_found" : "R3 not_found", not_found, !v.ef);
      if (v.ef) check("R2 cap_loc", cap_loc, v.eloc);
      check("R2 record reads", rec_reads, v.erd);
      check("R5 no writes", writes, 0);
      check("R1 first address", first_addr, 8'h34);
      check("R1 head reads", head_reads, 1);
    end

    // R10 results hold while idle
    repeat (10) @(negedge clk);
    check("R10 found held", found, 1'b1);

    // MSI, 32-bit control, 5 vectors -> field 3, per-vector-mask bit kept
    clear_space();
    cs[1] = 32'h0010_0146;
    cs[8'h34 >> 2] = 32'h0000_0050;
    cs[8'h50 >> 2] = {16'h0, 8'h70, 8'h01};
    cs[8'h70 >> 2] = {16'h010A, 8'h00, 8'h05};
    cs[8'h78 >> 2] = 32'hDEAD_BEEF;
    run(8'h05, 6'd5, 64'h0000_0001_FEE0_1003);
    check("R8 found msi", found, 1'b1);
    check("R5 cap_loc msi", cap_loc, 8'h70);
    check("R6 addr low", cs[8'h74 >> 2], 32'hFEE0_1000);
    check("R6 no upper write", cs[8'h78 >> 2], 32'hDEAD_BEEF);
    check("R7 control 32b", cs[8'h70 >> 2], {16'h013B, 8'h00, 8'h05});
    check("R8 command rmw", cs[1], 32'h0010_0546);
    check("R9 write count 32b", writes, 3);

    // MSI, 64-bit control with stale field, 63 vectors -> capped at 5
    clear_space();
    cs[1] = 32'h0000_0400;
    cs[8'h34 >> 2] = 32'h0000_0040;
    cs[8'h40 >> 2] = {16'h00F0, 8'h00, 8'h05};
    run(8'h05, 6'd63, 64'h1234_5678_9ABC_DEF0);
    check("R6 addr low 64b", cs[8'h44 >> 2], 32'h9ABC_DEF0);
    check("R6 addr high 64b", cs[8'h48 >> 2], 32'h1234_5678);
    check("R7 control 64b cap", cs[8'h40 >> 2], {16'h00D1, 8'h00, 8'h05});
    check("R8 command rmw 64b", cs[1], 32'h0000_0404);
    check("R9 write count 64b", writes, 4);

    // MSI with 0 vectors -> field 0
    clear_space();
    cs[8'h34 >> 2] = 32'h0000_0048;
    cs[8'h48 >> 2] = {16'h0000, 8'h00, 8'h05};
    run(8'h05, 6'd0, 64'h0);
    check("R7 control zero vectors", cs[8'h48 >> 2], {16'h0001, 8'h00, 8'h05});
    check("R8 command bits", cs[1], 32'h0000_0404);

    // R4 loop guard, R10 restart ignored and results cleared
    clear_space();
    cs[8'h34 >> 2] = 32'h0000_0040;
    cs[8'h40 >> 2] = {16'h0, 8'h40, 8'h01};
    @(negedge clk);
    target_id = 8'h05; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R10 results cleared on start", {found, not_found}, 2'b00);
    repeat (20) @(negedge clk);
    target_id = 8'h01; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int waited = 0;
      while (!done && waited < 3000) begin
        @(negedge clk);
        waited++;
      end
    end
    check("R4 loop not_found", not_found, 1'b1);
    check("R4 loop found", found, 1'b0);
    check("R4 record reads", rec_reads, 48);
    check("R10 start while busy ignored", head_reads, 1);
    check("R4 no writes", writes, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule